// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Condition Flags

This block is the arithmetic and logic stage of a small eight-bit accumulator processor. Each request carries an operation code, a register byte (the accumulator, an index register, or a memory byte that a read-modify-write sequence routes onto the register input), a memory operand byte and the current carry. One clock after a valid request the block presents the result byte and the Negative, Overflow, Zero and Carry flags. It also presents a mask of the flags the operation updates and a strobe that says whether the result goes back to a register.

The operations are add with carry and subtract with borrow. There are bitwise AND, OR and XOR, and shifts and rotates by one place in either direction. Increment and decrement are included. Compare and bit-test update flags only. Operand fetch, address generation, decimal arithmetic and the remaining status bits are handled elsewhere. Outputs change only on a clock edge where the valid input is high, so the sequencer can read them over several cycles.

Operation codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift left, 6 shift right, 7 rotate left, 8 rotate right, 9 increment, 10 decrement, 11 compare, 12 bit-test. Codes 13 to 15 are unused. Flag vector and mask bit positions: 3 = N, 2 = V, 1 = Z, 0 = C.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted and after its release, out_valid, result, res_write, flags and flag_mask are all zero until the first valid request is captured.
- R2: out_valid is high exactly in the cycle after a cycle with in_valid high. When in_valid is low, result, res_write, flags and flag_mask keep their values.
- R3: Add (code 0) gives reg + mem + carry_in modulo 256 with res_write high and mask 1111. C is the carry out of bit 7. V is set when both addends have the same sign bit and the result's sign bit differs.
- R4: Subtract (code 1) gives reg - mem - (1 - carry_in) modulo 256 with res_write high and mask 1111. C is 1 when no borrow occurs. V is set when reg and mem differ in sign and the result's sign differs from reg.
- R5: AND, OR and XOR (codes 2, 3, 4) give the bitwise combination of reg and mem with res_write high and mask 1010.
- R6: Shift left (code 5) moves reg bit 7 into C and fills bit 0 with 0. Shift right (code 6) moves reg bit 0 into C and fills bit 7 with 0, so N is always 0. Both have mask 1011 and res_write high.
- R7: Rotate left (code 7) moves carry_in into bit 0 and reg bit 7 into C. Rotate right (code 8) moves carry_in into bit 7 and reg bit 0 into C. Both have mask 1011 and res_write high.
- R8: Increment and decrement (codes 9, 10) give reg + 1 and reg - 1 modulo 256 (0xFF to 0x00, 0x00 to 0xFF) with mask 1010 and res_write high.
- R9: Compare (code 11) sets N and Z from reg - mem and sets C to 1 when reg >= mem unsigned. Mask is 1011, res_write is low and result equals reg.
- R10: Bit-test (code 12) copies mem bit 7 to N and mem bit 6 to V, and sets Z when reg AND mem is zero. Mask is 1110, res_write is low and result equals reg.
- R11: For every operation except bit-test, N equals result bit 7 and Z is set exactly when the result is zero. Every flag whose mask bit is 0 reads 0.
- R12: Codes 13 to 15 give mask 0000, flags 0000, res_write low and result equal to reg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; captures a new result |
| op | input | 4 | Operation code |
| reg_in | input | 8 | Register operand (accumulator, index or routed memory byte) |
| mem_in | input | 8 | Memory operand byte |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | High the cycle after a captured request |
| result | output | 8 | Result byte |
| res_write | output | 1 | Result is to be written back to a register |
| flags | output | 4 | New flags {N, V, Z, C} |
| flag_mask | output | 4 | Flags updated by this operation, same bit order |

## Verification
The bound checker watches, on every cycle, the one-cycle valid latency and the holding of outputs while idle. It also checks that unmasked flags read zero, that N and Z follow the result byte, that the logic operations carry the N/Z-only mask and that shift right never sets N. It further checks that compare and bit-test leave the register value untouched with no write strobe. The actual arithmetic cannot be seen from these per-cycle relations: the carry and overflow of add and subtract at their signed and unsigned boundaries, the carry fed into rotates, increment and decrement wrap-around, and the compare outcome for less, equal and greater operands are shown only by the bench's directed and random scenarios against its scoreboard.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [3:0]   op,
  input  logic [W-1:0] reg_in,
  input  logic [W-1:0] mem_in,
  input  logic         carry_in,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         res_write,
  output logic [3:0]   flags,
  output logic [3:0]   flag_mask
);
  localparam int MSB = W - 1;
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR  = 4'd3,
                         OP_XOR = 4'd4, OP_SHL = 4'd5, OP_SHR = 4'd6, OP_ROL = 4'd7,
                         OP_ROR = 4'd8, OP_INC = 4'd9, OP_DEC = 4'd10, OP_CMP = 4'd11,
                         OP_BIT = 4'd12;
  localparam logic [3:0] M_ALL = 4'b1111, M_NZ = 4'b1010, M_NZC = 4'b1011, M_NVZ = 4'b1110;

  logic         inv_b;
  logic [W-1:0] add_b;
  logic         add_ci;
  logic [W:0]   sum;
  logic         sum_v;

  assign inv_b  = (op == OP_SUB) || (op == OP_CMP);
  assign add_b  = inv_b ? ~mem_in : mem_in;
  assign add_ci = (op == OP_CMP) ? 1'b1 : carry_in;
  assign sum    = {1'b0, reg_in} + {1'b0, add_b} + {{W{1'b0}}, add_ci};
  assign sum_v  = (reg_in[MSB] == add_b[MSB]) && (sum[MSB] != reg_in[MSB]);

  logic [W-1:0] n_res;
  logic         n_c, n_v, n_wr;
  logic [3:0]   n_mask;
  logic         n_n, n_z;

  always_comb begin
    n_res  = reg_in;
    n_c    = 1'b0;
    n_v    = 1'b0;
    n_wr   = 1'b1;
    n_mask = M_NZ;
    case (op)
      OP_ADD, OP_SUB: begin
        n_res  = sum[MSB:0];
        n_c    = sum[W];
        n_v    = sum_v;
        n_mask = M_ALL;
      end
      OP_AND: n_res = reg_in & mem_in;
      OP_OR:  n_res = reg_in | mem_in;
      OP_XOR: n_res = reg_in ^ mem_in;
      OP_SHL, OP_ROL: begin
        n_res  = {reg_in[MSB-1:0], (op == OP_ROL) & carry_in};
        n_c    = reg_in[MSB];
        n_mask = M_NZC;
      end
      OP_SHR, OP_ROR: begin
        n_res  = {(op == OP_ROR) & carry_in, reg_in[MSB:1]};
        n_c    = reg_in[0];
        n_mask = M_NZC;
      end
      OP_INC: n_res = reg_in + 1'b1;
      OP_DEC: n_res = reg_in - 1'b1;
      OP_CMP: begin
        n_c    = sum[W];
        n_wr   = 1'b0;
        n_mask = M_NZC;
      end
      OP_BIT: begin
        n_v    = mem_in[MSB-1];
        n_wr   = 1'b0;
        n_mask = M_NVZ;
      end
      default: begin
        n_wr   = 1'b0;
        n_mask = 4'b0000;
      end
    endcase
  end

  assign n_n = (op == OP_BIT) ? mem_in[MSB] :
               (op == OP_CMP) ? sum[MSB]    : n_res[MSB];
  assign n_z = (op == OP_BIT) ? ((reg_in & mem_in) == '0) :
               (op == OP_CMP) ? (sum[MSB:0] == '0)        : (n_res == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      res_write <= 1'b0;
      flags     <= 4'b0000;
      flag_mask <= 4'b0000;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= n_res;
        res_write <= n_wr;
        flags     <= {n_n, n_v, n_z, n_c} & n_mask;
        flag_mask <= n_mask;
      end
    end
  end
endmodule

module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [3:0]   op,
  input logic [W-1:0] reg_in,
  input logic         out_valid,
  input logic [W-1:0] result,
  input logic         res_write,
  input logic [3:0]   flags,
  input logic [3:0]   flag_mask
);
  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(result) && $stable(flags) && $stable(flag_mask) && $stable(res_write)));
  // R11
  unmasked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~flag_mask) == 4'b0000);
  // R11
  neg_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res_write && flag_mask[3]) |-> (flags[3] == result[W-1]));
  // R11
  zero_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && res_write && flag_mask[1]) |-> (flags[1] == (result == '0)));
  // R5
  logic_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == 4'd2 || op == 4'd3 || op == 4'd4)) |=> (flag_mask == 4'b1010 && res_write));
  // R6
  shr_no_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd6) |=> !flags[3]);
  // R9
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd11) |=> (!res_write && result == $past(reg_in)));
  // R10
  bit_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 4'd12) |=> (!res_write && result == $past(reg_in)));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .reg_in(reg_in),
  .out_valid(out_valid), .result(result), .res_write(res_write),
  .flags(flags), .flag_mask(flag_mask)
);

// File: tb/acc_alu_test.sv
module acc_alu_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] reg_in = 8'd0, mem_in = 8'd0;
  logic       carry_in = 1'b0;
  logic       out_valid, res_write;
  logic [7:0] result;
  logic [3:0] flags, flag_mask;

  acc_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .reg_in(reg_in),
    .mem_in(mem_in), .carry_in(carry_in), .out_valid(out_valid), .result(result),
    .res_write(res_write), .flags(flags), .flag_mask(flag_mask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [7:0] res;
    logic [3:0] fl;
    logic [3:0] mk;
    logic       wr;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R3";
      4'd1: return "R4";
      4'd2, 4'd3, 4'd4: return "R5";
      4'd5, 4'd6: return "R6";
      4'd7, 4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      4'd11: return "R9";
      4'd12: return "R10";
      default: return "R12";
    endcase
  endfunction

  function automatic exp_t model(input logic [3:0] o, input logic [7:0] a,
                                 input logic [7:0] m, input logic c);
    exp_t e;
    int s;
    logic [7:0] r;
    e.res = a; e.fl = 4'b0000; e.mk = 4'b0000; e.wr = 1'b0; e.tag = tag_of(o);
    r = a;
    case (o)
      4'd0: begin
        s = int'(a) + int'(m) + int'(c); r = s[7:0];
        e.mk = 4'b1111; e.wr = 1;
        e.fl[0] = (s > 255);
        e.fl[2] = (a[7] == m[7]) && (r[7] != a[7]);
      end
      4'd1: begin
        s = int'(a) - int'(m) - (1 - int'(c)); r = s[7:0];
        e.mk = 4'b1111; e.wr = 1;
        e.fl[0] = (s >= 0);
        e.fl[2] = (a[7] != m[7]) && (r[7] != a[7]);
      end
      4'd2: begin r = a & m; e.mk = 4'b1010; e.wr = 1; end
      4'd3: begin r = a | m; e.mk = 4'b1010; e.wr = 1; end
      4'd4: begin r = a ^ m; e.mk = 4'b1010; e.wr = 1; end
      4'd5: begin r = a << 1; e.fl[0] = a[7]; e.mk = 4'b1011; e.wr = 1; end
      4'd6: begin r = a >> 1; e.fl[0] = a[0]; e.mk = 4'b1011; e.wr = 1; end
      4'd7: begin r = {a[6:0], c}; e.fl[0] = a[7]; e.mk = 4'b1011; e.wr = 1; end
      4'd8: begin r = {c, a[7:1]}; e.fl[0] = a[0]; e.mk = 4'b1011; e.wr = 1; end
      4'd9: begin r = a + 8'd1; e.mk = 4'b1010; e.wr = 1; end
      4'd10: begin r = a - 8'd1; e.mk = 4'b1010; e.wr = 1; end
      4'd11: begin
        r = a - m; e.mk = 4'b1011;
        e.fl[0] = (a >= m);
      end
      4'd12: begin
        e.mk = 4'b1110;
        e.fl[3] = m[7]; e.fl[2] = m[6]; e.fl[1] = ((a & m) == 8'd0);
      end
      default: ;
    endcase
    if (o <= 4'd11) begin
      e.fl[3] = r[7];
      e.fl[1] = (r == 8'd0);
    end
    if (e.wr) e.res = r;
    return e;
  endfunction

  task automatic drive(input logic [3:0] o, input logic [7:0] a,
                       input logic [7:0] m, input logic c);
    @(posedge clk); #1;
    op = o; reg_in = a; mem_in = m; carry_in = c; in_valid = 1'b1;
    q.push_back(model(o, a, m, c));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      if (q.size() == 0) begin
        check(0, "R2", "unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(result == e.res && flags == e.fl && flag_mask == e.mk && res_write == e.wr,
              e.tag, "res/flags/mask/wr",
              {result, flags, flag_mask, 3'b000, res_write},
              {e.res, e.fl, e.mk, 3'b000, e.wr});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] hold_r;
    logic [3:0] hold_f;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state while held
    check(out_valid == 0 && result == 0 && res_write == 0 && flags == 0 && flag_mask == 0,
          "R1", "reset state", {result, flags, flag_mask}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(out_valid == 0 && result == 0 && res_write == 0 && flags == 0 && flag_mask == 0,
          "R1", "after reset release", {result, flags, flag_mask}, 0);

    // R3 add: signed overflow, unsigned carry to zero, carry in
    drive(4'd0, 8'h50, 8'h50, 1'b0);
    drive(4'd0, 8'hFF, 8'h01, 1'b0);
    drive(4'd0, 8'h10, 8'h20, 1'b1);
    drive(4'd0, 8'h80, 8'h80, 1'b0);
    // R4 subtract: borrow, signed overflow, borrow in
    drive(4'd1, 8'h50, 8'hF0, 1'b1);
    drive(4'd1, 8'h80, 8'h01, 1'b1);
    drive(4'd1, 8'h05, 8'h05, 1'b0);
    drive(4'd1, 8'h05, 8'h05, 1'b1);
    // R5 logic
    drive(4'd2, 8'hF0, 8'h0F, 1'b1);
    drive(4'd3, 8'h80, 8'h01, 1'b0);
    drive(4'd4, 8'hAA, 8'h55, 1'b0);
    // R6 shifts
    drive(4'd5, 8'h81, 8'h00, 1'b1);
    drive(4'd6, 8'h81, 8'h00, 1'b1);
    drive(4'd6, 8'h01, 8'h00, 1'b0);
    // R7 rotates with carry through
    drive(4'd7, 8'h80, 8'h00, 1'b1);
    drive(4'd7, 8'h80, 8'h00, 1'b0);
    drive(4'd8, 8'h01, 8'h00, 1'b1);
    drive(4'd8, 8'h02, 8'h00, 1'b0);
    // R8 wrap
    drive(4'd9, 8'hFF, 8'h00, 1'b0);
    drive(4'd10, 8'h00, 8'h00, 1'b1);
    drive(4'd9, 8'h7F, 8'h00, 1'b0);
    // R9 compare less / equal / greater
    drive(4'd11, 8'h10, 8'h20, 1'b0);
    drive(4'd11, 8'h20, 8'h20, 1'b0);
    drive(4'd11, 8'hF0, 8'h01, 1'b0);
    // R10 bit-test
    drive(4'd12, 8'h0F, 8'hC0, 1'b1);
    drive(4'd12, 8'h41, 8'h41, 1'b0);
    // R12 unused codes
    drive(4'd13, 8'h3C, 8'hFF, 1'b1);
    drive(4'd14, 8'h00, 8'h00, 1'b0);
    drive(4'd15, 8'h99, 8'h12, 1'b1);
    idle(3);

    // R2: outputs hold while idle
    @(negedge clk);
    hold_r = result; hold_f = flag_mask;
    idle(4);
    @(negedge clk);
    check(out_valid == 0 && result == hold_r && flag_mask == hold_f, "R2", "hold while idle",
          {out_valid, result, flag_mask}, {1'b0, hold_r, hold_f});

    // R11 and all ops: random back-to-back traffic
    for (int i = 0; i < 600; i++) begin
      drive(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 1'($urandom));
      if ((i % 37) == 0) idle(2);
    end
    idle(3);
    repeat (2) @(negedge clk);
    check(q.size() == 0, "R2", "queue drained", q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule